// File: doc/BRIEF.md
# Two-Level Virtual Address Translation Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table in memory. A request carries the virtual address, the access kind (load, store or fetch) and the effective privilege. Alongside it come the translation-enable flag, the root page number, and the two status bits that relax user-page access (supervisor-may-touch-user) and let readable-by-execute pages be loaded (make-executable-readable). The walker reads page-table entries one at a time over a simple request/response memory port. It applies the full leaf validity and permission rules, and writes the entry back when the accessed or dirty flag must be set.

The result is either a physical address with read, write and execute permission flags, or a fault with an exception cause code. Both are shown on registered outputs during a one-cycle `done` pulse. Only one translation is in flight at a time; a request presented while the walker is busy is ignored.

Page-table entry layout: bit 0 valid (V), bit 1 readable (R), bit 2 writable (W), bit 3 executable (X), bit 4 user (U), bit 5 global, bit 6 accessed (A), bit 7 dirty (D), bits 31:10 physical page number (PPN). Access kind encoding: 0 load, 1 store, 2 fetch (3 is treated as a load). Privilege encoding: 0 user, 1 supervisor; 2 and 3 are machine.

Top module: `sv32_walker`

## Requirements
- R1: When `xlat_on` is 0 or the privilege is machine (2 or 3), the walker makes no memory request. In the cycle after the request is accepted, `done` shows `paddr` = zero-extended virtual address, with read, write and execute all set and no fault.
- R2: The first entry is read at root_ppn*4096 + va[31:22]*4. After a pointer entry (V=1, R=W=X=0) at the first level, the second entry is read at PPN*4096 + va[21:12]*4.
- R3: An entry with V=0 faults. So does a leaf with R=0 and W=1 (write-only or write+execute), and so does a pointer entry found at the second level.
- R4: A leaf with U=1 faults for privilege supervisor when `sum_bit` is 0 or the access is a fetch. A leaf with U=0 faults for privilege user.
- R5: A leaf at the first level whose PPN bits 9:0 are not all zero faults as misaligned.
- R6: A load needs R=1, or X=1 with `mxr_bit`=1. A store needs W=1. A fetch needs X=1. Otherwise the access faults.
- R7: On a successful leaf, A is set, and D too for a store. If that changes the entry, exactly one write of the updated entry is issued to the leaf's address before `done`; otherwise no write is issued.
- R8: On success at the second level, `paddr` = {PPN, va[11:0]}. At the first level (superpage), `paddr` = (PPN<<12) | va[21:0].
- R9: On success, `perm_r` = R or (X and `mxr_bit`), `perm_x` = X, and `perm_w` = W and (store or D already set).
- R10: A page fault reports cause 12 for a fetch, 13 for a load and 15 for a store. A memory response with `mem_err` reports an access fault, cause 1, 5 or 7 respectively. On a fault all permission flags are 0.
- R11: `mem_req` is a one-cycle pulse with no new request before the previous response. `done` is a one-cycle pulse. `req_valid` is ignored while `busy` is high.
- R12: After reset `busy`, `done`, `mem_req` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (sampled while idle) |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 2/3 machine |
| xlat_on | input | 1 | 1 = two-level translation, 0 = bare |
| root_ppn | input | 22 | Page number of the root table |
| sum_bit | input | 1 | Supervisor may access user pages |
| mxr_bit | input | 1 | Executable pages are readable |
| busy | output | 1 | Translation in progress |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 34 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for a write |
| mem_rvalid | input | 1 | Memory response valid |
| mem_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Translation failed |
| cause | output | 5 | Exception cause when faulting |
| paddr | output | 34 | Physical address |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |

## Verification
The assertions watch every cycle for the pulse shape of `mem_req` and `done`. They also check that any writeback carries the accessed flag and goes to the address just read, that a faulting result never grants a permission, and that a leaf accepted by the permission checker is never a reserved encoding. Only the bench's scenarios can show the values themselves. Those are the addresses of both table reads, the superpage and page address merge, each fault rule with its cause code, the permission flags, and whether a writeback happens at all, with the write count compared against the scoreboard.

// File: rtl/sv32_walk_pkg.sv
package sv32_walk_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_READ_PTE, S_CHECK, S_WRITEBACK, S_DONE
  } walk_state_e;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;

  function automatic logic [4:0] page_cause(input logic [1:0] acc);
    case (acc)
      ACC_FETCH: return 5'd12;
      ACC_STORE: return 5'd15;
      default:   return 5'd13;
    endcase
  endfunction

  function automatic logic [4:0] bus_cause(input logic [1:0] acc);
    case (acc)
      ACC_FETCH: return 5'd1;
      ACC_STORE: return 5'd7;
      default:   return 5'd5;
    endcase
  endfunction
endpackage

// File: rtl/pte_judge.sv
module pte_judge
  import sv32_walk_pkg::*;
#(
  parameter int PTE_W  = 32,
  parameter int FLAG_W = 10,
  parameter int IDX_W  = 10
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  input  logic [1:0]       priv,
  input  logic             sum_en,
  input  logic             mxr_en,
  input  logic             top_level,
  output logic             is_ptr,
  output logic             bad,
  output logic [PTE_W-1:0] pte_upd,
  output logic             need_wb,
  output logic             p_r,
  output logic             p_w,
  output logic             p_x
);
  logic v, r, w, x, u, d, leaf, st, fe, ld, mis, priv_u, priv_s;

  always_comb begin
    v  = pte[BIT_V];
    r  = pte[BIT_R];
    w  = pte[BIT_W];
    x  = pte[BIT_X];
    u  = pte[BIT_U];
    d  = pte[BIT_D];
    st = (acc == ACC_STORE);
    fe = (acc == ACC_FETCH);
    ld = !st && !fe;
    priv_u = (priv == 2'd0);
    priv_s = (priv == 2'd1);
    is_ptr = v && !r && !w && !x;
    leaf   = v && (r || w || x);
    mis    = top_level && (|pte[FLAG_W+IDX_W-1:FLAG_W]);
    bad = !v
        || (!r && w)
        || (leaf && u && !priv_u && (!sum_en || fe))
        || (leaf && !u && !priv_s)
        || (leaf && mis)
        || (leaf && ld && !(r || (x && mxr_en)))
        || (leaf && st && !w)
        || (leaf && fe && !x);
    pte_upd = pte;
    pte_upd[BIT_A] = 1'b1;
    if (st) pte_upd[BIT_D] = 1'b1;
    need_wb = (pte_upd != pte);
    p_r = r || (x && mxr_en);
    p_x = x;
    p_w = w && (st || d);
  end

  always_comb begin
    if (leaf && !bad)
      AST_LEAF_NOT_RESERVED: assert (!(w && !r)); // R3
  end
endmodule

// File: rtl/pa_merge.sv
module pa_merge #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 34,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [VA_W-1:0]       vaddr,
  input  logic [PA_W-OFF_W-1:0] ppn,
  input  logic                  top_level,
  input  logic                  bypass,
  output logic [PA_W-1:0]       pa
);
  localparam logic [PA_W-1:0] ONE = PA_W'(1);
  logic [PA_W-1:0] va_ext, keep;

  always_comb begin
    va_ext = {{(PA_W-VA_W){1'b0}}, vaddr};
    keep   = top_level ? ((ONE << (OFF_W + IDX_W)) - ONE) : ((ONE << OFF_W) - ONE);
    pa     = bypass ? va_ext : ({ppn, {OFF_W{1'b0}}} | (va_ext & keep));
  end
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
  import sv32_walk_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 34,
  parameter int PTE_W  = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int FLAG_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [1:0]            req_acc,
  input  logic [1:0]            req_priv,
  input  logic                  xlat_on,
  input  logic [PA_W-OFF_W-1:0] root_ppn,
  input  logic                  sum_bit,
  input  logic                  mxr_bit,
  output logic                  busy,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [PA_W-1:0]       mem_addr,
  output logic [PTE_W-1:0]      mem_wdata,
  input  logic                  mem_rvalid,
  input  logic                  mem_err,
  input  logic [PTE_W-1:0]      mem_rdata,
  output logic                  done,
  output logic                  fault,
  output logic [4:0]            cause,
  output logic [PA_W-1:0]       paddr,
  output logic                  perm_r,
  output logic                  perm_w,
  output logic                  perm_x
);
  localparam int PPN_W = PA_W - OFF_W;
  localparam int PAD_W = PA_W - IDX_W - 2;

  walk_state_e       st;
  logic              lvl_top;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q, priv_q;
  logic              sum_q, mxr_q;
  logic [PTE_W-1:0]  pte_q;

  logic              j_ptr, j_bad, j_wb, j_r, j_w, j_x;
  logic [PTE_W-1:0]  j_upd;
  logic [PA_W-1:0]   m_pa, top_addr, sub_addr;
  logic [VA_W-1:0]   m_va;
  logic              in_idle, go_bypass;

  assign in_idle   = (st == S_IDLE);
  assign busy      = !in_idle;
  assign m_va      = in_idle ? req_vaddr : va_q;
  assign go_bypass = !xlat_on || req_priv[1];
  assign top_addr  = {root_ppn, {OFF_W{1'b0}}}
                   + {{PAD_W{1'b0}}, req_vaddr[VA_W-1 -: IDX_W], 2'b00};
  assign sub_addr  = {pte_q[PTE_W-1:FLAG_W], {OFF_W{1'b0}}}
                   + {{PAD_W{1'b0}}, va_q[OFF_W+IDX_W-1:OFF_W], 2'b00};

  pte_judge #(.PTE_W(PTE_W), .FLAG_W(FLAG_W), .IDX_W(IDX_W)) u_judge (
    .pte(pte_q), .acc(acc_q), .priv(priv_q), .sum_en(sum_q), .mxr_en(mxr_q),
    .top_level(lvl_top), .is_ptr(j_ptr), .bad(j_bad), .pte_upd(j_upd),
    .need_wb(j_wb), .p_r(j_r), .p_w(j_w), .p_x(j_x)
  );

  pa_merge #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_merge (
    .vaddr(m_va), .ppn(pte_q[PTE_W-1:FLAG_W]), .top_level(lvl_top),
    .bypass(in_idle), .pa(m_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  lvl_top <= 1'b0;  va_q <= '0;  acc_q <= '0;
      priv_q <= '0;  sum_q <= 1'b0;  mxr_q <= 1'b0;  pte_q <= '0;
      mem_req <= 1'b0;  mem_we <= 1'b0;  mem_addr <= '0;  mem_wdata <= '0;
      done <= 1'b0;  fault <= 1'b0;  cause <= '0;  paddr <= '0;
      perm_r <= 1'b0;  perm_w <= 1'b0;  perm_x <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr;  acc_q <= req_acc;  priv_q <= req_priv;
          sum_q <= sum_bit;   mxr_q <= mxr_bit;
          if (go_bypass) begin
            paddr <= m_pa;  fault <= 1'b0;  cause <= '0;
            perm_r <= 1'b1;  perm_w <= 1'b1;  perm_x <= 1'b1;
            done <= 1'b1;  st <= S_DONE;
          end else begin
            lvl_top <= 1'b1;  mem_req <= 1'b1;  mem_we <= 1'b0;
            mem_addr <= top_addr;  st <= S_READ_PTE;
          end
        end
        S_READ_PTE: if (mem_rvalid) begin
          if (mem_err) begin
            fault <= 1'b1;  cause <= bus_cause(acc_q);  paddr <= '0;
            perm_r <= 1'b0;  perm_w <= 1'b0;  perm_x <= 1'b0;
            done <= 1'b1;  st <= S_DONE;
          end else begin
            pte_q <= mem_rdata;  st <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (j_ptr && lvl_top) begin
            lvl_top <= 1'b0;  mem_req <= 1'b1;  mem_we <= 1'b0;
            mem_addr <= sub_addr;  st <= S_READ_PTE;
          end else if (j_ptr || j_bad) begin
            fault <= 1'b1;  cause <= page_cause(acc_q);  paddr <= '0;
            perm_r <= 1'b0;  perm_w <= 1'b0;  perm_x <= 1'b0;
            done <= 1'b1;  st <= S_DONE;
          end else if (j_wb) begin
            mem_req <= 1'b1;  mem_we <= 1'b1;  mem_wdata <= j_upd;
            st <= S_WRITEBACK;
          end else begin
            paddr <= m_pa;  fault <= 1'b0;  cause <= '0;
            perm_r <= j_r;  perm_w <= j_w;  perm_x <= j_x;
            done <= 1'b1;  st <= S_DONE;
          end
        end
        S_WRITEBACK: if (mem_rvalid) begin
          mem_we <= 1'b0;
          if (mem_err) begin
            fault <= 1'b1;  cause <= bus_cause(acc_q);  paddr <= '0;
            perm_r <= 1'b0;  perm_w <= 1'b0;  perm_x <= 1'b0;
          end else begin
            paddr <= m_pa;  fault <= 1'b0;  cause <= '0;
            perm_r <= j_r;  perm_w <= j_w;  perm_x <= j_x;
          end
          done <= 1'b1;  st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_WB_SETS_A: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[BIT_A]); // R7
  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr == $past(mem_addr))); // R7
  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> !(perm_r || perm_w || perm_x)); // R10
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req && !done && !fault)); // R12
endmodule

// File: tb/tb_sv32_walker.sv
module tb_sv32_walker;
  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                         FU = 8'h10, FA = 8'h40, FD = 8'h80;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0] req_acc = '0, req_priv = '0;
  logic xlat_on = 1'b0, sum_bit = 1'b0, mxr_bit = 1'b0;
  logic [21:0] root_ppn = 22'h00100;
  logic busy, mem_req, mem_we, done, fault, perm_r, perm_w, perm_x;
  logic [33:0] mem_addr, paddr;
  logic [31:0] mem_wdata;
  logic mem_rvalid = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [4:0] cause;

  always #5 clk = ~clk;

  sv32_walker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_priv(req_priv), .xlat_on(xlat_on),
    .root_ppn(root_ppn), .sum_bit(sum_bit), .mxr_bit(mxr_bit), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .done(done), .fault(fault), .cause(cause),
    .paddr(paddr), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  int checks = 0, fails = 0;
  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem [logic [33:0]];
  bit errset [logic [33:0]];
  logic [33:0] pend_addr, last_addr;
  logic pend_we;
  logic [31:0] pend_wd, last_wd;
  int cnt = 0, wr_count = 0, req_count = 0;
  logic [33:0] first_rd_addr;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_err <= 1'b0;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_err <= errset.exists(pend_addr);
        mem_rdata <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
        if (pend_we && !errset.exists(pend_addr)) begin
          mem[pend_addr] = pend_wd;
          wr_count++;
          last_wd = pend_wd;
          last_addr = pend_addr;
        end
      end
    end
    if (mem_req) begin
      if (cnt != 0) begin
        checks++; fails++;
        $display("FAIL R11 request while outstanding actual=1 expected=0");
      end
      if (req_count == 0 || !mem_we) first_rd_addr = (req_count == 0) ? mem_addr : first_rd_addr;
      req_count++;
      pend_addr <= mem_addr; pend_we <= mem_we; pend_wd <= mem_wdata;
      cnt <= 2;
    end
  end

  typedef struct packed {
    logic        fault;
    logic [4:0]  cause;
    logic [33:0] pa;
    logic [2:0]  perm;
    logic [31:0] nwb;
    logic [31:0] wbd;
  } exp_t;
  exp_t exp_q[$];
  string tag_q[$];

  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " fault"}, 34'(fault), 34'(e.fault));
        check({t, " cause"}, 34'(cause), 34'(e.cause));
        if (!e.fault) begin
          check({t, " paddr"}, paddr, e.pa);
          check({t, " perm"}, 34'({perm_r, perm_w, perm_x}), 34'(e.perm));
        end
        check({t, " writes"}, 34'(wr_count), 34'(e.nwb));
        if (e.wbd != 0) check({t, " wdata"}, 34'(last_wd), 34'(e.wbd));
      end
    end
  end

  function automatic logic [31:0] mk(input logic [21:0] ppn, input logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction
  function automatic logic [31:0] va_of(input int v1, input int v0, input logic [11:0] off);
    return {10'(v1), 10'(v0), off};
  endfunction

  task automatic go(input string tag, input logic [31:0] va, input logic [1:0] acc,
                    input logic [1:0] priv, input logic ef, input logic [4:0] ec,
                    input logic [33:0] epa, input logic [2:0] eperm,
                    input int add_wb, input logic [31:0] ewd);
    exp_t e;
    e.fault = ef; e.cause = ec; e.pa = epa; e.perm = eperm;
    e.nwb = 32'(wr_count + add_wb); e.wbd = ewd;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_vaddr = va; req_acc = acc; req_priv = priv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int rc;
    logic [31:0] va;
    mem[34'h100004] = mk(22'h200, FV);
    mem[34'h200004] = mk(22'h12345, FV|FR|FW|FA|FD);
    mem[34'h200008] = mk(22'h12346, FV|FR|FW);
    mem[34'h20001C] = mk(22'h12347, FV|FR|FW);
    mem[34'h20000C] = mk(22'h00300, FV);
    mem[34'h200010] = mk(22'h22222, FV|FR|FU|FA|FD);
    mem[34'h200014] = mk(22'h22223, FV|FX|FU|FA);
    mem[34'h200018] = mk(22'h33333, FV|FX|FA);
    mem[34'h10000C] = mk(22'h00400, FV|FR|FX|FA);
    mem[34'h100010] = mk(22'h00401, FV|FR|FA);
    mem[34'h100018] = mk(22'h00010, FV|FW);
    mem[34'h100020] = mk(22'h00010, FV|FW|FX);
    errset[34'h10001C] = 1'b1;

    repeat (3) @(negedge clk);
    check("R12 busy", 34'(busy), 34'd0);
    check("R12 done", 34'(done), 34'd0);
    check("R12 mem_req", 34'(mem_req), 34'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R12 fault", 34'(fault), 34'd0);

    // R1 bare mode and machine privilege bypass
    rc = req_count;
    go("R1 bare", 32'hDEADBEEF, 2'd0, 2'd1, 0, 0, {2'b00, 32'hDEADBEEF}, 3'b111, 0, 0);
    xlat_on = 1'b1;
    go("R1 machine", 32'hFFFFF000, 2'd1, 2'd3, 0, 0, {2'b00, 32'hFFFFF000}, 3'b111, 0, 0);
    check("R1 no memory request", 34'(req_count), 34'(rc));

    // R2 R8 R9 two-level load, no writeback
    va = va_of(1, 1, 12'h234);
    go("R2 R8 load 4K", va, 2'd0, 2'd1, 0, 0, {22'h12345, 12'h234}, 3'b110, 0, 0);
    check("R2 root entry addr", first_rd_addr, 34'h100004);
    check("R2 leaf addr", 34'(pend_addr), 34'h200004);

    // R7 store sets A and D
    go("R7 store wb", va_of(1, 2, 12'h010), 2'd1, 2'd1, 0, 0, {22'h12346, 12'h010}, 3'b110, 1,
       mk(22'h12346, FV|FR|FW|FA|FD));
    check("R7 wb addr", last_addr, 34'h200008);
    go("R7 store again no wb", va_of(1, 2, 12'h020), 2'd1, 2'd1, 0, 0, {22'h12346, 12'h020}, 3'b110, 0, 0);
    // R7 R9 load sets only A; W reported off since D clear
    go("R7 R9 load wb", va_of(1, 7, 12'h004), 2'd0, 2'd1, 0, 0, {22'h12347, 12'h004}, 3'b100, 1,
       mk(22'h12347, FV|FR|FW|FA));

    // R8 superpage merge
    va = va_of(3, 5, 12'h678);
    go("R8 superpage", va, 2'd2, 2'd1, 0, 0, ({22'h400, 12'h000} | {12'h000, va[21:0]}), 3'b101, 0, 0);
    // R5 misaligned superpage
    go("R5 misaligned", va_of(4, 0, 12'h0), 2'd0, 2'd1, 1, 13, 0, 0, 0, 0);

    // R3 invalid, reserved, pointer at second level
    go("R3 V=0 load", va_of(5, 0, 12'h0), 2'd0, 2'd1, 1, 13, 0, 0, 0, 0);
    go("R3 V=0 store", va_of(5, 0, 12'h0), 2'd1, 2'd1, 1, 15, 0, 0, 0, 0);
    go("R3 R10 write-only fetch", va_of(6, 0, 12'h0), 2'd2, 2'd1, 1, 12, 0, 0, 0, 0);
    go("R3 write+exec", va_of(8, 0, 12'h0), 2'd2, 2'd1, 1, 12, 0, 0, 0, 0);
    go("R3 pointer at leaf level", va_of(1, 3, 12'h0), 2'd0, 2'd1, 1, 13, 0, 0, 0, 0);

    // R4 user/supervisor rules
    go("R4 user page sum=0", va_of(1, 4, 12'h0), 2'd0, 2'd1, 1, 13, 0, 0, 0, 0);
    sum_bit = 1'b1;
    go("R4 user page sum=1", va_of(1, 4, 12'h08C), 2'd0, 2'd1, 0, 0, {22'h22222, 12'h08C}, 3'b100, 0, 0);
    go("R4 user fetch from S", va_of(1, 5, 12'h0), 2'd2, 2'd1, 1, 12, 0, 0, 0, 0);
    sum_bit = 1'b0;
    go("R4 user mode on user page", va_of(1, 4, 12'h001), 2'd0, 2'd0, 0, 0, {22'h22222, 12'h001}, 3'b100, 0, 0);
    go("R4 user mode on S page", va_of(1, 1, 12'h0), 2'd0, 2'd0, 1, 13, 0, 0, 0, 0);

    // R6 access kind rules
    go("R6 exec-only load mxr=0", va_of(1, 6, 12'h0), 2'd0, 2'd1, 1, 13, 0, 0, 0, 0);
    mxr_bit = 1'b1;
    go("R6 R9 exec-only load mxr=1", va_of(1, 6, 12'h0F0), 2'd0, 2'd1, 0, 0, {22'h33333, 12'h0F0}, 3'b101, 0, 0);
    mxr_bit = 1'b0;
    go("R6 store no W", va_of(1, 6, 12'h0), 2'd1, 2'd1, 1, 15, 0, 0, 0, 0);
    go("R6 fetch no X", va_of(1, 1, 12'h0), 2'd2, 2'd1, 1, 12, 0, 0, 0, 0);

    // R10 response error causes
    go("R10 load access fault", va_of(7, 0, 12'h0), 2'd0, 2'd1, 1, 5, 0, 0, 0, 0);
    go("R10 fetch access fault", va_of(7, 0, 12'h0), 2'd2, 2'd1, 1, 1, 0, 0, 0, 0);
    go("R10 store access fault", va_of(7, 0, 12'h0), 2'd1, 2'd1, 1, 7, 0, 0, 0, 0);

    // R11 requests while busy are ignored
    begin
      exp_t e;
      e.fault = 0; e.cause = 0; e.pa = {22'h12345, 12'h555}; e.perm = 3'b110;
      e.nwb = 32'(wr_count); e.wbd = 0;
      exp_q.push_back(e);
      tag_q.push_back("R11 busy walk");
      @(negedge clk);
      req_vaddr = va_of(1, 1, 12'h555); req_acc = 2'd0; req_priv = 2'd1; req_valid = 1'b1;
      @(negedge clk);
      req_priv = 2'd3; req_vaddr = 32'h12345678;
      repeat (3) @(negedge clk);
      check("R11 still busy", 34'(busy), 34'd1);
      while (!done) @(negedge clk);
      req_valid = 1'b0;
      repeat (6) @(negedge clk);
      check("R11 one result only", 34'(exp_q.size()), 34'd0);
      check("R11 idle after", 34'(busy), 34'd0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule